// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the external memory bus of an 8-bit microcontroller core. Time is cut into machine cycles of six states, and each state lasts two clocks, so one machine cycle is twelve clocks. During a cycle the block drives one of four bus patterns: idle, a pair of instruction fetches, a data read or a data write. A single 8-bit port carries two things in turn. It first drives the low half of the address while a latch-enable pulse tells an external latch to capture it. Afterwards it carries the data byte. A separate 8-bit port drives the high half of the address.

The core presents a request kind together with a program counter, a data pointer, an indirect byte and write data. The block samples these at the edge that closes the last clock of a machine cycle, and `req_take` marks that clock. The sampled request then sets the bus pattern for the whole of the next cycle. In a fetch cycle the program-store strobe pulses twice, first for the program counter and then for the program counter plus one. Each fetched byte is returned on `rdata`. For a data access the low address comes from either the indirect byte or the pointer's low byte, and the high address always comes from the pointer's high byte. Reads and writes use their own active-low strobes.

Top module: `ext_bus_seq`

## Requirements
- R1: A machine cycle is 12 clocks, numbered 0 to 11 from the first clock after reset is released. `req_take` is high only during clock 11 of every cycle.
- R2: While reset is low, and in the first cycle after it, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `a_hi` is 0 and `rdata_valid` is 0.
- R3: In a fetch cycle (`req_kind` = 1), `psen_n` is low during clocks 3, 4, 9 and 10 and high during every other clock.
- R4: In a fetch cycle, clocks 0 to 5 use address PC and clocks 6 to 11 use PC+1, with PC+1 wrapping modulo 2^16. `a_hi` shows the high byte of the current address. `ad_out` shows its low byte with `ad_oe` high during clocks 0 to 2 and clocks 6 to 8. `ale` is high during clocks 0, 1, 6 and 7.
- R5: The block samples `ad_in` on the edge that ends clock 4 and on the edge that ends clock 10 of a fetch cycle. Each sampled byte appears on `rdata` with `rdata_valid` and `rdata_code` high for exactly the following clock (5 or 11).
- R6: In a data cycle the address is {dptr[15:8], use_ri ? ri : dptr[7:0]}. `a_hi` holds dptr[15:8] for all 12 clocks, and `ad_out` shows the low byte with `ad_oe` high during clocks 0 to 2.
- R7: In a read cycle (`req_kind` = 2), `rd_n` is low during clocks 3 to 9 and `ad_oe` is 0 during clocks 3 to 11. The block samples `ad_in` on the edge that ends clock 9, and the byte appears with `rdata_valid` high and `rdata_code` low during clock 10.
- R8: In a write cycle (`req_kind` = 3), `wr_n` is low during clocks 3 to 9, and `ad_out` carries `wdata` with `ad_oe` high during clocks 3 to 10.
- R9: `psen_n` stays high for the whole of a read or write cycle, `rd_n` and `wr_n` stay high for the whole of a fetch cycle, and at most one strobe is ever low.
- R10: `ale` falls one clock before the port stops driving the address. It is never high while a strobe is low.
- R11: In an idle cycle (`req_kind` = 0) no strobe or `ale` is active, `ad_oe` is 0 and `a_hi` is 0.
- R12: Request inputs are sampled only at the edge that ends clock 11. Changing them during any other clock has no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock is one state phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_kind | input | 2 | Request for next cycle: 0 idle, 1 fetch, 2 read, 3 write |
| pc | input | 16 | Program counter for a fetch |
| dptr | input | 16 | Data pointer for a data access |
| ri | input | 8 | Indirect low address byte |
| use_ri | input | 1 | Take the low data address from `ri` instead of dptr[7:0] |
| wdata | input | 8 | Byte to write |
| ad_in | input | 8 | Value read back from the multiplexed port |
| req_take | output | 1 | High during the clock whose closing edge samples the request |
| ad_out | output | 8 | Value driven on the multiplexed address/data port |
| ad_oe | output | 1 | Drive enable for the multiplexed port |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Last byte captured from the port |
| rdata_valid | output | 1 | `rdata` was captured on the previous edge |
| rdata_code | output | 1 | The captured byte is an instruction byte |

## Verification
The hardest case to reach from the ports is a request that changes in the middle of a machine cycle, because the design must still hold the values it sampled at the cycle boundary. To reach it, the bench fills every request input with random values during clocks 0 to 10 and presents the real request only in clock 11. The bench also places random values on `ad_in` outside the strobe windows, so a sample taken one clock early or late picks up the wrong byte. The sweep runs every cycle kind against addresses chosen to expose wrap and carry, including FFFF and 12FF for the second fetch, and runs each of them with both low-address sources.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_FETCH = 2'd1,
    K_READ  = 2'd2,
    K_WRITE = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [15:0] addr;
    logic [7:0]  wbyte;
  } cmd_t;

  // address of the second instruction byte in a fetch cycle
  function automatic logic [15:0] bump(input logic [15:0] a);
    return a + 16'd1;
  endfunction

  // external data address: high byte from the pointer, low byte selectable
  function automatic logic [15:0] data_addr(input logic [15:0] ptr,
                                            input logic [7:0]  ind,
                                            input logic        sel_ind);
    return {ptr[15:8], sel_ind ? ind : ptr[7:0]};
  endfunction

endpackage

// File: rtl/ebs_slot_timer.sv
module ebs_slot_timer #(
  parameter int TICKS = 12,
  localparam int TW = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tick,
  output logic          last
);

  assign last = (tick == TW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tick <= '0;
    else if (last) tick <= '0;
    else           tick <= tick + 1'b1;
  end

  // R1
  take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last);

endmodule

// File: rtl/ebs_cmd_latch.sv
module ebs_cmd_latch
  import ebs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [1:0]  req_kind,
  input  logic [15:0] pc,
  input  logic [15:0] dptr,
  input  logic [7:0]  ri,
  input  logic        use_ri,
  input  logic [7:0]  wdata,
  output cmd_t        cmd
);

  kind_e       k_in;
  logic [15:0] a_in;

  assign k_in = kind_e'(req_kind);
  assign a_in = (k_in == K_FETCH) ? pc : data_addr(dptr, ri, use_ri);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd <= '{kind: K_IDLE, addr: 16'h0000, wbyte: 8'h00};
    end else if (take) begin
      cmd <= '{kind: k_in, addr: a_in, wbyte: wdata};
    end
  end

endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen
  import ebs_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int TICKS = STATES * PHASES,
  localparam int HALF  = TICKS / 2,
  localparam int TW    = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tick,
  input  kind_e         kind,
  output logic          ale,
  output logic          fetch_str,
  output logic          rd_str,
  output logic          wr_str,
  output logic          addr_drv,
  output logic          data_drv,
  output logic          sample,
  output logic          second_half
);

  always_comb begin
    int t;
    int h;
    t = int'(tick);
    h = (t >= HALF) ? t - HALF : t;
    ale = 1'b0; fetch_str = 1'b0; rd_str = 1'b0; wr_str = 1'b0;
    addr_drv = 1'b0; data_drv = 1'b0; sample = 1'b0; second_half = 1'b0;
    unique case (kind)
      K_FETCH: begin
        second_half = (t >= HALF);
        ale         = (h < PHASES);
        addr_drv    = (h <= PHASES);
        fetch_str   = (h > PHASES) && (h < HALF - 1);
        sample      = (h == HALF - 2);
      end
      K_READ: begin
        ale      = (t < PHASES);
        addr_drv = (t <= PHASES);
        rd_str   = (t > PHASES) && (t < TICKS - 2);
        sample   = (t == TICKS - 3);
      end
      K_WRITE: begin
        ale      = (t < PHASES);
        addr_drv = (t <= PHASES);
        wr_str   = (t > PHASES) && (t < TICKS - 2);
        data_drv = (t > PHASES) && (t < TICKS - 1);
      end
      default: ;
    endcase
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_str, rd_str, wr_str}));

  // R10
  ale_vs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !(fetch_str || rd_str || wr_str));

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  req_kind,
  input  logic [15:0] pc,
  input  logic [15:0] dptr,
  input  logic [7:0]  ri,
  input  logic        use_ri,
  input  logic [7:0]  wdata,
  input  logic [7:0]  ad_in,
  output logic        req_take,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  a_hi,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  rdata,
  output logic        rdata_valid,
  output logic        rdata_code
);

  localparam int TICKS = STATES * PHASES;
  localparam int TW    = $clog2(TICKS);

  logic [TW-1:0] tick;
  logic          last;
  cmd_t          cmd;
  logic          fetch_str, rd_str, wr_str;
  logic          addr_drv, data_drv, sample, second_half;
  logic [15:0]   cur_addr;
  logic          data_cyc;

  ebs_slot_timer #(.TICKS(TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .last(last)
  );

  ebs_cmd_latch u_cmd (
    .clk(clk), .rst_n(rst_n), .take(last),
    .req_kind(req_kind), .pc(pc), .dptr(dptr), .ri(ri),
    .use_ri(use_ri), .wdata(wdata), .cmd(cmd)
  );

  ebs_strobe_gen #(.STATES(STATES), .PHASES(PHASES)) u_str (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kind(cmd.kind),
    .ale(ale), .fetch_str(fetch_str), .rd_str(rd_str), .wr_str(wr_str),
    .addr_drv(addr_drv), .data_drv(data_drv), .sample(sample),
    .second_half(second_half)
  );

  assign req_take = last;
  assign data_cyc = (cmd.kind == K_READ) || (cmd.kind == K_WRITE);
  assign cur_addr = second_half ? bump(cmd.addr) : cmd.addr;

  assign ad_out = addr_drv ? cur_addr[7:0] : (data_drv ? cmd.wbyte : 8'h00);
  assign ad_oe  = addr_drv || data_drv;
  assign a_hi   = (cmd.kind == K_IDLE) ? 8'h00 : cur_addr[15:8];
  assign psen_n = !fetch_str;
  assign rd_n   = !rd_str;
  assign wr_n   = !wr_str;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata       <= 8'h00;
      rdata_valid <= 1'b0;
      rdata_code  <= 1'b0;
    end else begin
      rdata_valid <= sample;
      if (sample) begin
        rdata      <= ad_in;
        rdata_code <= (cmd.kind == K_FETCH);
      end
    end
  end

  // R7
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R10
  ale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ad_oe);

  // R6
  ahi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cyc && tick != '0) |-> $stable(a_hi));

  // R5
  sample_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(!psen_n || !rd_n));

endmodule

// File: tb/ext_bus_seq_test.sv
`timescale 1ns/1ps
module ext_bus_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] pc = 16'h0, dptr = 16'h0;
  logic [7:0]  ri = 8'h0, wdata = 8'h0, ad_in = 8'h0;
  logic        use_ri = 1'b0;
  logic        req_take, ad_oe, ale, psen_n, rd_n, wr_n, rdata_valid, rdata_code;
  logic [7:0]  ad_out, a_hi, rdata;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  ext_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .pc(pc), .dptr(dptr),
    .ri(ri), .use_ri(use_ri), .wdata(wdata), .ad_in(ad_in),
    .req_take(req_take), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .rdata(rdata), .rdata_valid(rdata_valid), .rdata_code(rdata_code)
  );

  // model of the cycle in progress
  int          m_kind = 0;
  logic [15:0] m_addr = 16'h0;
  logic [7:0]  m_wd = 8'h0;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hC3;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_tick(input int t);
    int h;
    logic [15:0] a;
    logic e_ale, e_oe, e_ps, e_rd, e_wr, e_v, e_code;
    logic [7:0] e_ad, e_hi, e_rb;
    h = t % 6;
    a = m_addr;
    e_ale = 0; e_oe = 0; e_ps = 1; e_rd = 1; e_wr = 1; e_v = 0; e_code = 0;
    e_ad = 8'h00; e_hi = 8'h00; e_rb = 8'h00;
    case (m_kind)
      1: begin // fetch: R3 R4 R5
        if (t >= 6) a = m_addr + 16'd1;
        e_ale = (h < 2); e_oe = (h < 3); e_ps = !(h == 3 || h == 4);
        e_ad = a[7:0]; e_hi = a[15:8];
        e_v = (h == 5); e_code = 1; e_rb = mem(a);
      end
      2: begin // read: R6 R7
        e_ale = (t < 2); e_oe = (t < 3); e_rd = !(t >= 3 && t <= 9);
        e_ad = a[7:0]; e_hi = a[15:8];
        e_v = (t == 10); e_code = 0; e_rb = mem(a);
      end
      3: begin // write: R6 R8
        e_ale = (t < 2); e_oe = (t <= 10); e_wr = !(t >= 3 && t <= 9);
        e_ad = (t < 3) ? a[7:0] : m_wd; e_hi = a[15:8];
      end
      default: ; // idle: R11
    endcase
    chk("R1", "req_take", 16'(req_take), 16'(t == 11));
    chk("R10", "ale", 16'(ale), 16'(e_ale));
    chk("R4/R7", "ad_oe", 16'(ad_oe), 16'(e_oe));
    chk("R3/R9", "psen_n", 16'(psen_n), 16'(e_ps));
    chk("R7/R9", "rd_n", 16'(rd_n), 16'(e_rd));
    chk("R8/R9", "wr_n", 16'(wr_n), 16'(e_wr));
    chk("R6/R11", "a_hi", 16'(a_hi), 16'(e_hi));
    if (e_oe) chk("R4/R8", "ad_out", 16'(ad_out), 16'(e_ad));
    chk("R5/R7", "rdata_valid", 16'(rdata_valid), 16'(e_v));
    if (e_v) begin
      chk("R5/R7", "rdata", 16'(rdata), 16'(e_rb));
      chk("R5/R7", "rdata_code", 16'(rdata_code), 16'(e_code));
    end
  endtask

  // bus read-back: correct byte only inside the strobe window
  task automatic drive_bus(input int t);
    logic [15:0] a;
    a = (m_kind == 1 && t >= 6) ? m_addr + 16'd1 : m_addr;
    if ((m_kind == 1 && (t % 6 == 3 || t % 6 == 4)) ||
        (m_kind == 2 && t >= 3 && t <= 9))
      ad_in = mem(a);
    else
      ad_in = 8'($urandom);
  endtask

  initial begin : watchdog
    #1000000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    logic [15:0] alist [6];
    int          n_kind;
    logic [15:0] n_addr;
    logic [7:0]  n_wd;
    alist[0] = 16'h0000; alist[1] = 16'hFFFF; alist[2] = 16'h12FF;
    alist[3] = 16'hA55A; alist[4] = 16'h00FF; alist[5] = 16'h7F80;

    // R2: outputs while reset is held
    repeat (3) @(negedge clk);
    chk("R2", "ale", 16'(ale), 16'h0);
    chk("R2", "psen_n", 16'(psen_n), 16'h1);
    chk("R2", "rd_n", 16'(rd_n), 16'h1);
    chk("R2", "wr_n", 16'(wr_n), 16'h1);
    chk("R2", "ad_oe", 16'(ad_oe), 16'h0);
    chk("R2", "rdata_valid", 16'(rdata_valid), 16'h0);
    @(posedge clk); #1 rst_n = 1'b1;

    for (int cyc = 0; cyc <= 48; cyc++) begin
      n_kind = 0; n_addr = 16'h0; n_wd = 8'h0;
      for (int t = 0; t < 12; t++) begin
        @(negedge clk);
        check_tick(t);
        drive_bus(t);
        if (t == 11) begin
          if (cyc < 48) begin
            int j, sel;
            j = (cyc / 4) % 6;
            sel = cyc / 24;
            n_kind = (cyc % 4 == 3) ? 0 : (cyc % 4) + 1;
            pc = alist[j];
            dptr = alist[j] ^ 16'h0F0F;
            ri = alist[j][7:0] ^ 8'hA5;
            use_ri = sel[0];
            wdata = alist[j][15:8] ^ 8'h3C;
            req_kind = 2'(n_kind);
            n_addr = (n_kind == 1) ? pc : {dptr[15:8], use_ri ? ri : dptr[7:0]};
            n_wd = wdata;
          end else begin
            req_kind = 2'd0;
          end
        end else begin
          // R12: junk on request inputs outside the sampling clock
          req_kind = 2'($urandom); pc = 16'($urandom); dptr = 16'($urandom);
          ri = 8'($urandom); use_ri = 1'($urandom); wdata = 8'($urandom);
        end
      end
      m_kind = n_kind; m_addr = n_addr; m_wd = n_wd;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule